// File: doc/BRIEF.md
# Subcarrier Load Modulator

This block produces the card-to-reader answer of a proximity card. A carrier enable pulses once per 13.56 MHz cycle. A programmable divider with a phase offset turns these pulses into a sample tick. Each tick is one half-period of the 847.5 kHz subcarrier, so with the usual divide-by-8 the ticks come at 1.695 MHz. Each data bit lasts sixteen ticks. The bit either keys the subcarrier on and off in one half of the bit (Manchester) or flips the subcarrier phase whenever the data value changes (BPSK).

Data bits arrive on a valid/ready stream. The block keeps a single holding slot. It raises ready when that slot is empty. A held bit is always taken at the next bit boundary, so the request for bit N+1 is open for the whole of bit N. When a boundary comes and no bit is held, modulation stops. The transmit control byte selects the mode in its low nibble and gives a drive depth in its high nibble. The depth is passed straight to a 2-bit output that sets the modulation strength.

Top module: `subcarrier_modulator`

## Requirements
- R1: An internal count advances on each cycle with `carrier_en` high and wraps after `tx_div`-1. Values of `tx_div` below 2 act as 1. A sample tick happens on the `carrier_en` cycle in which the count equals `tx_phase`. A phase above `tx_div`-1 acts as `tx_div`-1. The count is 0 after reset.
- R2: After reset, and whenever no bit is being sent, `mod_en` is 0 and `bit_ready` is 1 while the holding slot is empty.
- R3: A bit is taken on a rising clock edge with `bit_valid` and `bit_ready` both high. `bit_ready` then stays low until that bit starts. The source holds `bit_valid` and `bit_data` until the bit is taken.
- R4: A held bit starts on the first tick after the edge that took it, never on that same edge. It lasts exactly 16 ticks. A bit held at a boundary follows with no gap. If no bit is held at a boundary, `mod_en` goes to 0 from that tick on.
- R5: Within a bit, the slots are numbered 0 to 15. The subcarrier is 1 in even slots and 0 in odd slots.
- R6: With control bits [3:0] = 2 (Manchester), a 1 bit drives the subcarrier in slots 0-7 and 0 in slots 8-15. A 0 bit drives 0 in slots 0-7 and the subcarrier in slots 8-15.
- R7: With control bits [3:0] = 1 (BPSK), `mod_en` is the subcarrier XOR a phase flag. The flag is 0 for the first bit after idle. It toggles at each boundary where the new bit differs from the one before.
- R8: With any other value of control bits [3:0], `mod_en` stays 0. Bits are still taken and used at the normal rate.
- R9: `mod_depth` is control bits [5:4] when bits [7:6] are 0, and 3 otherwise. It follows the control input without a clock.
- R10: Cycles with `carrier_en` low neither advance the count nor produce ticks, so the whole output timeline stretches with the carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_en | input | 1 | One pulse per carrier cycle |
| tx_div | input | DIV_W | Carrier cycles per sample tick |
| tx_phase | input | DIV_W | Tick position within the divider period |
| tx_ctrl | input | 8 | Mode in [3:0], depth in [7:4] |
| bit_valid | input | 1 | Stream data valid |
| bit_data | input | 1 | Stream data bit |
| bit_ready | output | 1 | Holding slot empty, bit accepted when valid |
| mod_en | output | 1 | Load modulation switch |
| mod_depth | output | 2 | Modulation depth code |

## Verification
The assertions assume that `tx_div` and `tx_phase` stay constant between resets. They also assume that the mode nibble changes only while no bit is running, and that the source never withdraws a valid bit before it is taken. The bench writes every divider, phase and mode setting while reset is held. It then leaves those settings alone for the whole frame, and it keeps `bit_valid` high until it has seen `bit_ready`. Only the depth nibble is changed on the fly, and only while the block is idle.

// File: rtl/submod_pkg.sv
package submod_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [NIB_W-1:0] {
    KEY_NONE  = 4'd0,
    KEY_BPSK  = 4'd1,
    KEY_MANCH = 4'd2
  } key_e;

  // Upper nibble of the control byte to the 2-bit drive code.
  function automatic logic [1:0] sat_depth(input logic [NIB_W-1:0] nib);
    return (nib > 4'd3) ? 2'd3 : nib[1:0];
  endfunction

endpackage

// File: rtl/sample_clock_gen.sv
module sample_clock_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carrier_en,
  input  logic [DIV_W-1:0] div,
  input  logic [DIV_W-1:0] phase,
  output logic             tick
);
  localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;
  logic [DIV_W-1:0] ph;

  always_comb begin
    last = (div < TWO) ? '0 : div - 1'b1;
    ph   = (phase > last) ? last : phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (carrier_en) begin
      cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = carrier_en && (cnt == ph);

  // R1: with a period of two or more, ticks never fall on adjacent cycles
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (last != '0)) |=> !tick);

endmodule

// File: rtl/bit_sequencer.sv
module bit_sequencer #(
  parameter int HALVES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      bit_valid,
  input  logic                      bit_data,
  output logic                      bit_ready,
  output logic                      active,
  output logic [$clog2(HALVES)-1:0] slot,
  output logic                      load,
  output logic                      load_bit,
  output logic                      cont
);
  localparam int SLOT_W = $clog2(HALVES);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(HALVES - 1);

  logic pend_v;
  logic pend_b;
  logic boundary;

  assign boundary  = !active || (slot == LAST);
  assign load      = tick && boundary && pend_v;
  assign load_bit  = pend_b;
  assign cont      = active;
  assign bit_ready = !pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (tick) begin
      if (boundary) begin
        active <= pend_v;
        slot   <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_b <= 1'b0;
    end else if (load) begin
      pend_v <= 1'b0;
    end else if (bit_valid && bit_ready) begin
      pend_v <= 1'b1;
      pend_b <= bit_data;
    end
  end

  // R3: a taken bit closes the slot until it is consumed
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready) |=> !bit_ready);

  // R4: inside a bit each tick advances exactly one slot
  p_slot_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active && (slot != LAST)) |=> (active && (slot == $past(slot) + 1'b1)));

  // R4: a boundary with nothing held ends modulation
  p_run_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && boundary && bit_ready) |=> !active);

endmodule

// File: rtl/subcarrier_encoder.sv
module subcarrier_encoder
  import submod_pkg::*;
#(
  parameter int HALVES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      load_bit,
  input  logic                      cont,
  input  logic [NIB_W-1:0]          key,
  input  logic                      active,
  input  logic [$clog2(HALVES)-1:0] slot,
  output logic                      mod_en
);
  localparam int SLOT_W = $clog2(HALVES);
  localparam logic [SLOT_W-1:0] HALF = SLOT_W'(HALVES / 2);

  logic [NIB_W-1:0] mode_q;
  logic             cur_b;
  logic             flip;
  logic             sub;
  logic             first;
  logic             raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= KEY_NONE;
      cur_b  <= 1'b0;
      flip   <= 1'b0;
    end else if (load) begin
      mode_q <= key;
      cur_b  <= load_bit;
      flip   <= cont ? (flip ^ (load_bit != cur_b)) : 1'b0;
    end
  end

  always_comb begin
    sub   = ~slot[0];
    first = (slot < HALF);
    case (mode_q)
      KEY_BPSK:  raw = sub ^ flip;
      KEY_MANCH: raw = sub & (first ? cur_b : ~cur_b);
      default:   raw = 1'b0;
    endcase
    mod_en = active & raw;
  end

  // R8: unknown mode keys never switch the load
  p_bad_key_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q != KEY_BPSK) && (mode_q != KEY_MANCH)) |-> !mod_en);

  // R2: no modulation outside a running bit
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mod_en);

endmodule

// File: rtl/subcarrier_modulator.sv
module subcarrier_modulator
  import submod_pkg::*;
#(
  parameter int DIV_W          = 8,
  parameter int HALVES_PER_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carrier_en,
  input  logic [DIV_W-1:0] tx_div,
  input  logic [DIV_W-1:0] tx_phase,
  input  logic [7:0]       tx_ctrl,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic             mod_en,
  output logic [1:0]       mod_depth
);
  localparam int SLOT_W = $clog2(HALVES_PER_BIT);

  logic              tick;
  logic              active;
  logic [SLOT_W-1:0] slot;
  logic              load;
  logic              load_bit;
  logic              cont;

  sample_clock_gen #(.DIV_W(DIV_W)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_en (carrier_en),
    .div        (tx_div),
    .phase      (tx_phase),
    .tick       (tick)
  );

  bit_sequencer #(.HALVES(HALVES_PER_BIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .bit_ready (bit_ready),
    .active    (active),
    .slot      (slot),
    .load      (load),
    .load_bit  (load_bit),
    .cont      (cont)
  );

  subcarrier_encoder #(.HALVES(HALVES_PER_BIT)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_bit (load_bit),
    .cont     (cont),
    .key      (tx_ctrl[3:0]),
    .active   (active),
    .slot     (slot),
    .mod_en   (mod_en)
  );

  assign mod_depth = sat_depth(tx_ctrl[7:4]);

endmodule

// File: tb/subcarrier_modulator_test.sv
module subcarrier_modulator_test;
  localparam int HB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       carrier_en = 1'b1;
  logic [7:0] tx_div = 8'd8;
  logic [7:0] tx_phase = 8'd0;
  logic [7:0] tx_ctrl = 8'h22;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       bit_ready;
  logic       mod_en;
  logic [1:0] mod_depth;

  int checks = 0;
  int errors = 0;
  int edge_no = 0;
  int ccnt = 0;
  bit ev = 1'b0;
  int gate = 0;
  int div_eff;
  int ph_eff;
  string cfg_tag = "R1";

  int    exp_val[$];
  int    exp_edge[$];
  string exp_tag[$];

  always #5 clk = ~clk;

  subcarrier_modulator uut (
    .clk(clk), .rst_n(rst_n), .carrier_en(carrier_en),
    .tx_div(tx_div), .tx_phase(tx_phase), .tx_ctrl(tx_ctrl),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .mod_en(mod_en), .mod_depth(mod_depth)
  );

  always_comb begin
    div_eff = (tx_div < 8'd2) ? 1 : int'(tx_div);
    ph_eff  = (int'(tx_phase) > div_eff - 1) ? div_eff - 1 : int'(tx_phase);
  end

  // Reference tick model (R1, R10)
  always @(posedge clk) begin
    edge_no <= edge_no + 1;
    if (!rst_n) begin
      ccnt <= 0;
      ev   <= 1'b0;
    end else begin
      ev <= carrier_en && ((ccnt % div_eff) == ph_eff);
      if (carrier_en) ccnt <= ccnt + 1;
    end
  end

  always @(negedge clk)
    carrier_en <= (gate == 0) ? 1'b1 : ((edge_no % 3) != 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected value per tick
  always @(negedge clk) begin
    if (rst_n && ev) begin
      if (exp_val.size() > 0 && exp_edge[0] < edge_no) begin
        check(mod_en == exp_val[0], exp_tag[0], mod_en, exp_val[0]);
        void'(exp_val.pop_front());
        void'(exp_edge.pop_front());
        void'(exp_tag.pop_front());
      end else begin
        check(mod_en == 1'b0, "R4 no bit held", mod_en, 0);
      end
    end
  end

  task automatic do_reset(input logic [7:0] d, input logic [7:0] p, input logic [7:0] c, input int g);
    rst_n = 1'b0;
    bit_valid = 1'b0;
    tx_div = d; tx_phase = p; tx_ctrl = c; gate = g;
    exp_val.delete(); exp_edge.delete(); exp_tag.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] pat, input int n);
    int  flip = 0;
    logic prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = pat[i];
      if (i > 0 && b != prev) flip ^= 1;
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data  = b;
      while (!bit_ready) @(negedge clk);
      for (int s = 0; s < HB; s++) begin
        int sub;
        int e;
        sub = (s % 2 == 0) ? 1 : 0;
        case (tx_ctrl[3:0])
          4'd1:    e = sub ^ flip;
          4'd2:    e = (s < HB/2) ? (b ? sub : 0) : (b ? 0 : sub);
          default: e = 0;
        endcase
        exp_val.push_back(e);
        exp_edge.push_back(edge_no + 1);
        case (tx_ctrl[3:0])
          4'd1:    exp_tag.push_back({"R5/R7 ", cfg_tag});
          4'd2:    exp_tag.push_back({"R5/R6 ", cfg_tag});
          default: exp_tag.push_back({"R8 ", cfg_tag});
        endcase
      end
      @(negedge clk);
      bit_valid = 1'b0;
      check(bit_ready == 1'b0, "R3 slot held", bit_ready, 0);
      prev = b;
    end
  endtask

  task automatic wait_idle();
    int lim = 0;
    while (exp_val.size() > 0 && lim < 20000) begin
      @(negedge clk);
      lim++;
    end
    check(exp_val.size() == 0, "R8 R4 bits consumed", exp_val.size(), 0);
    repeat (6 * div_eff) @(negedge clk);
    check(bit_ready == 1'b1, "R2 idle ready", bit_ready, 1);
    check(mod_en == 1'b0, "R2 idle quiet", mod_en, 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state
    do_reset(8'd8, 8'd0, 8'h22, 0);
    check(mod_en == 1'b0, "R2 reset mod_en", mod_en, 0);
    check(bit_ready == 1'b1, "R2 reset ready", bit_ready, 1);
    check(mod_depth == 2'd2, "R9 reset depth", mod_depth, 2);

    // Depth mapping while idle
    for (int k = 0; k < 16; k++) begin
      int e;
      tx_ctrl = {4'(k), 4'd2};
      e = (k > 3) ? 3 : k;
      #1;
      check(mod_depth == 2'(e), "R9 depth map", mod_depth, e);
    end
    tx_ctrl = 8'h22;

    // Manchester, divide 8, phase 0
    cfg_tag = "R1";
    send_frame(32'b11001, 5);
    wait_idle();

    // BPSK with phase offset
    do_reset(8'd8, 8'd3, 8'h11, 0);
    send_frame(32'b100110, 6);
    wait_idle();
    send_frame(32'b0101, 4);
    wait_idle();

    // Unknown mode key: silent, bits still consumed
    do_reset(8'd8, 8'd5, 8'h03, 0);
    send_frame(32'b101, 3);
    wait_idle();
    do_reset(8'd6, 8'd1, 8'h0F, 0);
    send_frame(32'b01, 2);
    wait_idle();

    // Phase beyond the period is clipped
    do_reset(8'd4, 8'd7, 8'h31, 0);
    send_frame(32'b0011, 4);
    wait_idle();

    // Divider below 2 ticks every carrier cycle
    do_reset(8'd0, 8'd5, 8'h02, 0);
    send_frame(32'b0110, 4);
    wait_idle();

    // Gated carrier stretches the timeline
    cfg_tag = "R10";
    do_reset(8'd8, 8'd2, 8'h12, 1);
    send_frame(32'b1010, 4);
    wait_idle();
    do_reset(8'd5, 8'd4, 8'h01, 1);
    send_frame(32'b110, 3);
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule